// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog. It sits on a small single-cycle register bus and exposes three words: a control/status word, a command word that also returns the running count when read, and a timeout word. A counter advances on a slow tick input (nominally 1 kHz, so the timeout holds seconds times 1000). When the watchdog is enabled and the count reaches the timeout, the block drives a fixed-length reset pulse and starts counting again from zero.

Software protects the configuration with magic keys written to the command word. An unlock key opens a short configuration window. A different keep-alive key clears the count. A control bit selects the key form: either one full 32-bit key word, or two ordered 16-bit halves written back to back. Software can also give up the right to reconfigure. After that, every unlock attempt is ignored until the next hardware reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control word reads 0x0000_00A0, meaning enabled (bit 7) and reconfiguration allowed (bit 5), with 16-bit key form (bit 13 = 0), the unlocked flag (bit 11) clear and the done flag (bit 10) clear. The timeout word reads 128000 (0x1F400) and the count reads 0. The word offsets are control 0x0, command/count 0x4 and timeout 0x8.
- R2: A write to the control or timeout word while the block is locked changes nothing.
- R3: In 16-bit form, writing 0x0000_C520 and then 0x0000_D928 to the command word sets the unlocked flag (bit 11).
- R4: In 16-bit form, a command write after the first unlock half that is not 0x0000_D928 aborts the sequence. A later lone 0x0000_D928 does not unlock.
- R5: In 32-bit form (bit 13 = 1), the word 0xD928_C520 unlocks, the word 0xB480_A602 clears the count, and the 16-bit halves are ignored. An unlock clears the done flag.
- R6: The unlocked flag clears by itself 128 bus cycles after the unlock. A configuration write after that is ignored.
- R7: The first write to the control or timeout word while unlocked takes effect, clears the unlocked flag and sets the done flag (bit 10).
- R8: Once a configuration has written bit 5 as 0, no unlock is accepted until reset.
- R9: While enabled, each tick adds one to the count. When the count reaches the timeout, the reset output goes high for exactly 16 bus cycles and the count returns to 0.
- R10: In 16-bit form, 0x0000_A602 followed by 0x0000_B480 clears the count. Any other command value leaves the count unchanged, and so does a keep-alive while disabled.
- R11: While disabled, the count holds its value and the reset output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| slow_tick | input | 1 | One-cycle count enable from the slow time base |
| wdog_rst | output | 1 | Reset request pulse |

## Verification
A key sequencer left in the wrong state shows up at the next command write. Either an unlock appears in bit 11 that should not, or a valid second half fails to unlock, so the control word read right after the pair exposes it. A window counter that is off by one or stuck moves the moment bit 11 falls, and that is visible within about 130 cycles of the unlock. A pulse counter or compare fault shows up as a reset pulse of the wrong length or at the wrong tick, and the bench measures this directly on the reset output.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

   localparam int OFS_CTRL = 'h0;
   localparam int OFS_CMD  = 'h4;
   localparam int OFS_TOV  = 'h8;

   localparam int BIT_CMD32 = 13;
   localparam int BIT_UNLK  = 11;
   localparam int BIT_DONE  = 10;
   localparam int BIT_EN    = 7;
   localparam int BIT_UPD   = 5;

   localparam logic [15:0] KEY_UNLK_LO = 16'hC520;
   localparam logic [15:0] KEY_UNLK_HI = 16'hD928;
   localparam logic [15:0] KEY_REF_LO  = 16'hA602;
   localparam logic [15:0] KEY_REF_HI  = 16'hB480;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_UNLK_PEND,
      SEQ_REF_PEND
   } seq_e;

   typedef struct packed {
      logic cmd32;
      logic upd;
      logic en;
   } wd_cfg_t;

endpackage

// File: rtl/kwd_key_decoder.sv
module kwd_key_decoder
   import kwd_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit HALF_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              mode32,
   output logic              unlock_hit,
   output logic              refresh_hit
);

   localparam int HALF_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] UNLK_WORD = {KEY_UNLK_HI, KEY_UNLK_LO};
   localparam logic [DATA_W-1:0] REF_WORD  = {KEY_REF_HI, KEY_REF_LO};

   logic full_unlk, full_ref;
   logic half_unlk, half_ref;

   assign full_unlk = cmd_we && mode32 && (cmd_wdata == UNLK_WORD);
   assign full_ref  = cmd_we && mode32 && (cmd_wdata == REF_WORD);

   generate
      if (HALF_MODE_EN) begin : g_half
         seq_e seq_q, seq_d;
         logic half_we;

         assign half_we = cmd_we && !mode32;

         always_comb begin
            seq_d     = seq_q;
            half_unlk = 1'b0;
            half_ref  = 1'b0;
            if (mode32) begin
               seq_d = SEQ_IDLE;
            end else if (half_we) begin
               unique case (seq_q)
                  SEQ_UNLK_PEND: begin
                     half_unlk = (cmd_wdata == {{HALF_W{1'b0}}, KEY_UNLK_HI});
                     seq_d     = SEQ_IDLE;
                  end
                  SEQ_REF_PEND: begin
                     half_ref = (cmd_wdata == {{HALF_W{1'b0}}, KEY_REF_HI});
                     seq_d    = SEQ_IDLE;
                  end
                  default: begin
                     if (cmd_wdata == {{HALF_W{1'b0}}, KEY_UNLK_LO})
                        seq_d = SEQ_UNLK_PEND;
                     else if (cmd_wdata == {{HALF_W{1'b0}}, KEY_REF_LO})
                        seq_d = SEQ_REF_PEND;
                     else
                        seq_d = SEQ_IDLE;
                  end
               endcase
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seq_q <= SEQ_IDLE;
            else        seq_q <= seq_d;
         end
      end else begin : g_full_only
         logic unused_half;
         assign unused_half = &{1'b0, clk, rst_n};
         assign half_unlk   = 1'b0;
         assign half_ref    = 1'b0;
      end
   endgenerate

   assign unlock_hit  = full_unlk | half_unlk;
   assign refresh_hit = full_ref | half_ref;

endmodule

// File: rtl/kwd_unlock_ctrl.sv
module kwd_unlock_ctrl
   import kwd_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 17,
   parameter int WIN           = 128,
   parameter int RESET_TIMEOUT = 128000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unlock_hit,
   input  logic              ctrl_we,
   input  logic              tov_we,
   input  logic [DATA_W-1:0] wdata,
   output wd_cfg_t           cfg,
   output logic [CNT_W-1:0]  toval,
   output logic              unlocked,
   output logic              done
);

   localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);
   localparam logic [CNT_W-1:0] TOV_RST  = CNT_W'(RESET_TIMEOUT);

   logic [WIN_W-1:0] win_q;
   logic             cfg_write;

   assign cfg_write = unlocked && (ctrl_we || tov_we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '{cmd32: 1'b0, upd: 1'b1, en: 1'b1};
         toval    <= TOV_RST;
         unlocked <= 1'b0;
         done     <= 1'b0;
         win_q    <= '0;
      end else if (unlock_hit && cfg.upd) begin
         unlocked <= 1'b1;
         done     <= 1'b0;
         win_q    <= WIN_LAST;
      end else if (cfg_write) begin
         unlocked <= 1'b0;
         done     <= 1'b1;
         if (ctrl_we) begin
            cfg.cmd32 <= wdata[BIT_CMD32];
            cfg.upd   <= wdata[BIT_UPD];
            cfg.en    <= wdata[BIT_EN];
         end
         if (tov_we) toval <= wdata[CNT_W-1:0];
      end else if (unlocked) begin
         if (win_q == '0) unlocked <= 1'b0;
         else             win_q    <= win_q - 1'b1;
      end
   end

   logic unused_bits;
   assign unused_bits = &{1'b0, wdata};

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
   parameter int CNT_W = 17,
   parameter int PULSE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             refresh,
   input  logic [CNT_W-1:0] toval,
   output logic [CNT_W-1:0] cnt,
   output logic             rst_req
);

   localparam int PW = $clog2(PULSE + 1);
   localparam logic [PW-1:0] PULSE_LEN = PW'(PULSE);

   logic [PW-1:0] pulse_q;
   logic          expired;

   assign expired = en && (cnt >= toval);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         pulse_q <= '0;
      end else if (pulse_q != '0) begin
         pulse_q <= pulse_q - 1'b1;
         cnt     <= '0;
      end else if (expired) begin
         pulse_q <= PULSE_LEN;
         cnt     <= '0;
      end else if (en && refresh) begin
         cnt <= '0;
      end else if (en && tick && (cnt != '1)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign rst_req = (pulse_q != '0);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwd_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 17,
   parameter int UNLOCK_WIN    = 128,
   parameter int RST_PULSE     = 16,
   parameter int RESET_TIMEOUT = 128000,
   parameter bit HALF_MODE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              slow_tick,
   output logic              wdog_rst
);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("keyed_watchdog: DATA_W must be 32");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("keyed_watchdog: ADDR_W must cover offset 0x8");
      end
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt
         $error("keyed_watchdog: CNT_W out of range");
      end else if (RESET_TIMEOUT >= (1 << CNT_W)) begin : g_bad_tov
         $error("keyed_watchdog: RESET_TIMEOUT does not fit CNT_W");
      end
      if (UNLOCK_WIN < 2) begin : g_bad_win
         $error("keyed_watchdog: UNLOCK_WIN must be at least 2");
      end
      if (RST_PULSE < 1) begin : g_bad_pulse
         $error("keyed_watchdog: RST_PULSE must be at least 1");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
   localparam logic [ADDR_W-1:0] A_TOV  = ADDR_W'(OFS_TOV);

   logic             wr_any, ctrl_we, cmd_we, tov_we;
   logic             unlock_hit, refresh_hit;
   logic             unlocked, done;
   wd_cfg_t          cfg;
   logic [CNT_W-1:0] toval, cnt;

   assign wr_any  = bus_sel && bus_wr;
   assign ctrl_we = wr_any && (bus_addr == A_CTRL);
   assign cmd_we  = wr_any && (bus_addr == A_CMD);
   assign tov_we  = wr_any && (bus_addr == A_TOV);

   kwd_key_decoder #(
      .DATA_W       (DATA_W),
      .HALF_MODE_EN (HALF_MODE_EN)
   ) u_keys (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_we      (cmd_we),
      .cmd_wdata   (bus_wdata),
      .mode32      (cfg.cmd32),
      .unlock_hit  (unlock_hit),
      .refresh_hit (refresh_hit)
   );

   kwd_unlock_ctrl #(
      .DATA_W        (DATA_W),
      .CNT_W         (CNT_W),
      .WIN           (UNLOCK_WIN),
      .RESET_TIMEOUT (RESET_TIMEOUT)
   ) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .unlock_hit (unlock_hit),
      .ctrl_we    (ctrl_we),
      .tov_we     (tov_we),
      .wdata      (bus_wdata),
      .cfg        (cfg),
      .toval      (toval),
      .unlocked   (unlocked),
      .done       (done)
   );

   kwd_counter #(
      .CNT_W (CNT_W),
      .PULSE (RST_PULSE)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (slow_tick),
      .en      (cfg.en),
      .refresh (refresh_hit),
      .toval   (toval),
      .cnt     (cnt),
      .rst_req (wdog_rst)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL) begin
         bus_rdata[BIT_CMD32] = cfg.cmd32;
         bus_rdata[BIT_UNLK]  = unlocked;
         bus_rdata[BIT_DONE]  = done;
         bus_rdata[BIT_EN]    = cfg.en;
         bus_rdata[BIT_UPD]   = cfg.upd;
      end else if (bus_addr == A_CMD) begin
         bus_rdata[CNT_W-1:0] = cnt;
      end else if (bus_addr == A_TOV) begin
         bus_rdata[CNT_W-1:0] = toval;
      end
   end

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 17,
   parameter int WIN    = 128,
   parameter int PULSE  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wdog_rst,
   input logic              unlocked,
   input logic              done,
   input logic              cfg_en,
   input logic              cfg_upd,
   input logic              cfg_cmd32,
   input logic [CNT_W-1:0]  cnt
);

   logic        ctrl_wr, cfg_wr;
   logic [15:0] pulse_len, win_len;

   assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
   assign cfg_wr  = bus_sel && bus_wr &&
                    ((bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(8)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_len <= '0;
         win_len   <= '0;
      end else begin
         pulse_len <= wdog_rst ? pulse_len + 1'b1 : '0;
         win_len   <= unlocked ? win_len + 1'b1 : '0;
      end
   end

   // R2: locked control writes leave the configuration alone
   p_locked_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !unlocked) |=> $stable({cfg_en, cfg_upd, cfg_cmd32}));

   // R6: the window never stays open longer than WIN cycles
   p_window_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      win_len <= 16'(WIN));

   // R7: a configuration write while unlocked closes the window and sets done
   p_cfg_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && unlocked) |=> (!unlocked && done));

   // R8: once reconfiguration is forbidden, the block stays locked
   p_sealed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_upd && !unlocked) |=> !unlocked);

   // R9: the reset pulse lasts exactly PULSE cycles
   p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdog_rst) |-> (pulse_len == 16'(PULSE)));

   p_pulse_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_len <= 16'(PULSE));

   p_pulse_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_rst) |-> (cnt == '0));

   // R11: disabled means frozen count and no new pulse
   p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !wdog_rst) |=> ($stable(cnt) && !wdog_rst));

endmodule

bind keyed_watchdog keyed_watchdog_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .WIN    (UNLOCK_WIN),
   .PULSE  (RST_PULSE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .wdog_rst  (wdog_rst),
   .unlocked  (unlocked),
   .done      (done),
   .cfg_en    (cfg.en),
   .cfg_upd   (cfg.upd),
   .cfg_cmd32 (cfg.cmd32),
   .cnt       (cnt)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0, tick = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        wrst;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   keyed_watchdog uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (sel),
      .bus_wr    (wr),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .slow_tick (tick),
      .wdog_rst  (wrst)
   );

   typedef struct packed {
      logic        is_wr;
      logic [3:0]  a;
      logic [31:0] d;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'h0, 32'h0000_00A0, 4'd1},  // R1 control reset value
      '{1'b0, 4'h8, 32'h0001_F400, 4'd1},  // R1 timeout reset value
      '{1'b0, 4'h4, 32'h0000_0000, 4'd1},  // R1 count zero
      '{1'b1, 4'h8, 32'h0000_0032, 4'd2},  // R2 locked timeout write
      '{1'b0, 4'h8, 32'h0001_F400, 4'd2},
      '{1'b1, 4'h0, 32'h0000_0000, 4'd2},  // R2 locked control write
      '{1'b0, 4'h0, 32'h0000_00A0, 4'd2},
      '{1'b1, 4'h4, 32'h0000_C520, 4'd3},  // R3 first half
      '{1'b1, 4'h4, 32'h0000_D928, 4'd3},  // R3 second half
      '{1'b0, 4'h0, 32'h0000_08A0, 4'd3},
      '{1'b1, 4'h8, 32'h0000_0028, 4'd7},  // R7 config write closes window
      '{1'b0, 4'h0, 32'h0000_04A0, 4'd7},
      '{1'b0, 4'h8, 32'h0000_0028, 4'd7},
      '{1'b1, 4'h4, 32'h0000_C520, 4'd4},  // R4 abort sequence
      '{1'b1, 4'h4, 32'h0000_1234, 4'd4},
      '{1'b1, 4'h4, 32'h0000_D928, 4'd4},
      '{1'b0, 4'h0, 32'h0000_04A0, 4'd4},
      '{1'b1, 4'h4, 32'h0000_C520, 4'd5},  // R5 switch to 32-bit form
      '{1'b1, 4'h4, 32'h0000_D928, 4'd5},
      '{1'b1, 4'h0, 32'h0000_20A0, 4'd5},
      '{1'b0, 4'h0, 32'h0000_24A0, 4'd5},
      '{1'b1, 4'h4, 32'h0000_C520, 4'd5},  // R5 halves ignored
      '{1'b1, 4'h4, 32'h0000_D928, 4'd5},
      '{1'b0, 4'h0, 32'h0000_24A0, 4'd5},
      '{1'b1, 4'h4, 32'hD928_C520, 4'd5},  // R5 full unlock word
      '{1'b0, 4'h0, 32'h0000_28A0, 4'd5},
      '{1'b1, 4'h0, 32'h0000_0000, 4'd8},  // R8 forbid reconfiguration
      '{1'b0, 4'h0, 32'h0000_0400, 4'd8},
      '{1'b1, 4'h4, 32'h0000_C520, 4'd8},
      '{1'b1, 4'h4, 32'h0000_D928, 4'd8},
      '{1'b0, 4'h0, 32'h0000_0400, 4'd8}   // R8 still locked
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #2;
      d = rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic unlock16();
      bus_write(4'h4, 32'h0000_C520);
      bus_write(4'h4, 32'h0000_D928);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      int hi;
      int seen;

      // table walk: R1 R2 R3 R4 R5 R7 R8
      do_reset();
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr) begin
            bus_write(VECS[i].a, VECS[i].d);
         end else begin
            bus_read(VECS[i].a, rd);
            check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].d);
         end
      end

      // R9 / R10: counting, keep-alive, expiry pulse
      do_reset();
      check("R1 reset output low", {31'd0, wrst}, 32'd0);
      unlock16();
      bus_write(4'h8, 32'd10);
      ticks(5);
      bus_read(4'h4, rd);
      check("R9 count after 5 ticks", rd, 32'd5);
      bus_write(4'h4, 32'h0000_A602);
      bus_write(4'h4, 32'h0000_B480);
      bus_read(4'h4, rd);
      check("R10 keep-alive clears count", rd, 32'd0);
      ticks(3);
      bus_write(4'h4, 32'h1234_5678);
      bus_read(4'h4, rd);
      check("R10 other value ignored", rd, 32'd3);
      ticks(6);
      check("R9 no pulse before timeout", {31'd0, wrst}, 32'd0);
      ticks(1);
      seen = 0;
      for (int i = 0; i < 5; i++) begin
         if (wrst) begin seen = 1; break; end
         @(negedge clk);
      end
      check("R9 pulse seen", seen, 1);
      hi = 0;
      while (wrst && hi < 40) begin
         hi++;
         @(negedge clk);
      end
      check("R9 pulse length", hi, 16);
      bus_read(4'h4, rd);
      check("R9 count cleared after expiry", rd, 32'd0);

      // R6: window expiry
      do_reset();
      unlock16();
      repeat (120) @(negedge clk);
      bus_read(4'h0, rd);
      check("R6 still unlocked at 120", rd[11], 1'b1);
      repeat (20) @(negedge clk);
      bus_read(4'h0, rd);
      check("R6 window closed", rd[11], 1'b0);
      bus_write(4'h8, 32'd77);
      bus_read(4'h8, rd);
      check("R6 late write ignored", rd, 32'h0001_F400);

      // R5 / R10 / R11: 32-bit keep-alive, disabled behaviour
      do_reset();
      unlock16();
      bus_write(4'h0, 32'h0000_20A0);
      ticks(3);
      bus_read(4'h4, rd);
      check("R9 count in 32-bit form", rd, 32'd3);
      bus_write(4'h4, 32'hB480_A602);
      bus_read(4'h4, rd);
      check("R5 full keep-alive word", rd, 32'd0);
      ticks(4);
      bus_write(4'h4, 32'hD928_C520);
      bus_write(4'h0, 32'h0000_2020);
      ticks(5);
      bus_read(4'h4, rd);
      check("R11 count frozen when disabled", rd, 32'd4);
      check("R11 no reset when disabled", {31'd0, wrst}, 32'd0);
      bus_write(4'h4, 32'hB480_A602);
      bus_read(4'h4, rd);
      check("R10 keep-alive ignored when disabled", rd, 32'd4);

      finish_run();
   end

endmodule